// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block is an up-counting timer with a small word-addressed register port. Software loads a compare value, sets the run bit, and receives a one-cycle interrupt pulse each time the count steps onto the compare value. In free-running mode the count carries on past the compare value and wraps from all ones to zero. In periodic mode it returns to zero on the step after the compare value, so the timer produces a steady train of events.

The register port and the interrupt live in the bus clock domain. The counter itself runs from a separate count clock, which must be slower than the bus clock. A 2-bit prescale code stretches each count step over one to four count-clock cycles. Writing the clear register zeroes the count. Because that request has to reach the counting domain, a status flag stays raised until the counter has acknowledged it. Software polls this flag before it relies on a zero count.

Top module: `match_timer`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Byte offset 0x00 holds the compare value and 0x10 holds the prescale code in bits [1:0]. Offset 0x08 holds run in bit 0 and periodic in bit 1. Each of these reads back as written. Offset 0x04 returns the count and ignores writes. Offset 0x0C reads zero.
- R3: While running, the count advances by one every D count-clock cycles, where D is the prescale code plus one (codes 0, 1, 2 and 3 give D = 1, 2, 3 and 4).
- R4: Each step of the count onto the compare value produces exactly one `irq` pulse, one bus cycle wide.
- R5: With periodic clear, the count moves on past the compare value. It wraps from all ones (2^CNT_W - 1) to zero, so events repeat every 2^CNT_W steps.
- R6: With periodic set, the count returns to zero on the step after it equals the compare value M, so events repeat every M+1 steps.
- R7: With run clear, the count holds its value and no `irq` pulse occurs.
- R8: Any write to offset 0x0C zeroes the count, whatever the write data.
- R9: Status at offset 0x14, bit 10, reads 1 from the cycle after a write to 0x0C until the counting domain has applied the clear, and reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| cnt_clk | input | 1 | Count clock, slower than `clk` |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Match event pulse, bus domain |

## Verification
The wrap from all ones is the hardest case to reach, because the count cannot be loaded. The bench therefore builds the timer with an 8-bit counter, lets it run free, and measures the bus-cycle gap between successive interrupts against 256·D count-clock periods. The count clock has a fixed period of three bus periods. This makes the latency through the synchronizers constant, so every event interval across the sweep of prescale codes and compare values is an exact figure. The clear-pending flag is caught by reading status in the very next bus cycle after the clear write, before the slow domain can answer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 5;
    localparam int DIV_W    = 2;
    localparam int PEND_BIT = 10;

    typedef enum logic [2:0] {
        SEL_MATCH = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_CLEAR = 3'd3,
        SEL_DIV   = 3'd4,
        SEL_STAT  = 3'd5,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // quasi-static configuration carried into the count domain
    typedef struct packed {
        logic             periodic;
        logic             run;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        case (a[4:2])
            3'd0:    return SEL_MATCH;
            3'd1:    return SEL_COUNT;
            3'd2:    return SEL_CTRL;
            3'd3:    return SEL_CLEAR;
            3'd4:    return SEL_DIV;
            3'd5:    return SEL_STAT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= d;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             clr_req_i,
    input  logic             pub_ack_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o,
    output logic             clr_hit_o,
    output logic             run_o,
    output logic             periodic_o,
    output logic [CNT_W-1:0] match_o,
    output logic             match_tgl_o,
    output logic             clr_ack_o,
    output logic             pub_tgl_o,
    output logic [CNT_W-1:0] pub_data_o
);
    localparam int XW = CNT_W + CFG_W;

    logic [XW-1:0]    cfg_bus_s;
    cfg_t             cfg_s;
    logic [CNT_W-1:0] match_s;
    logic             clr_req_s, pub_ack_s;

    tmr_sync #(.WIDTH(XW)) u_cfg_sync (
        .clk(clk), .rst(rst), .d({cfg_i, match_i}), .q(cfg_bus_s)
    );
    tmr_sync #(.WIDTH(2)) u_hs_sync (
        .clk(clk), .rst(rst), .d({clr_req_i, pub_ack_i}), .q({clr_req_s, pub_ack_s})
    );

    assign cfg_s   = cfg_t'(cfg_bus_s[XW-1:CNT_W]);
    assign match_s = cfg_bus_s[CNT_W-1:0];

    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] count_q, step_val, pub_data_q;
    logic             clr_ack_q, match_tgl_q, pub_tgl_q;
    logic             clr_hit, tick;

    assign clr_hit  = (clr_req_s != clr_ack_q);
    assign tick     = cfg_s.run && !clr_hit && (pre_q >= cfg_s.div);
    assign step_val = (cfg_s.periodic && (count_q == match_s)) ? '0 : count_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q       <= '0;
            count_q     <= '0;
            clr_ack_q   <= 1'b0;
            match_tgl_q <= 1'b0;
        end else if (clr_hit) begin
            count_q   <= '0;
            pre_q     <= '0;
            clr_ack_q <= clr_req_s;
        end else if (!cfg_s.run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q   <= '0;
            count_q <= step_val;
            if (step_val == match_s)
                match_tgl_q <= ~match_tgl_q;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // count snapshot handed to the bus domain by toggle handshake
    always_ff @(posedge clk) begin
        if (rst) begin
            pub_tgl_q  <= 1'b0;
            pub_data_q <= '0;
        end else if (pub_ack_s == pub_tgl_q) begin
            pub_data_q <= count_q;
            pub_tgl_q  <= ~pub_tgl_q;
        end
    end

    assign count_o     = count_q;
    assign tick_o      = tick;
    assign clr_hit_o   = clr_hit;
    assign run_o       = cfg_s.run;
    assign periodic_o  = cfg_s.periodic;
    assign match_o     = match_s;
    assign match_tgl_o = match_tgl_q;
    assign clr_ack_o   = clr_ack_q;
    assign pub_tgl_o   = pub_tgl_q;
    assign pub_data_o  = pub_data_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output cfg_t              cfg_o,
    output logic [CNT_W-1:0]  match_o,
    output logic              clr_req_o,
    input  logic              clr_ack_i,
    input  logic              match_tgl_i,
    input  logic              pub_tgl_i,
    input  logic [CNT_W-1:0]  pub_data_i,
    output logic              pub_ack_o,
    output logic              irq_o,
    output logic              clr_pend_o
);
    logic     clr_ack_s, match_tgl_s, pub_tgl_s;
    reg_sel_e sel;

    tmr_sync #(.WIDTH(3)) u_back_sync (
        .clk(clk), .rst(rst),
        .d({clr_ack_i, match_tgl_i, pub_tgl_i}),
        .q({clr_ack_s, match_tgl_s, pub_tgl_s})
    );

    assign sel = decode_addr(bus_addr);

    cfg_t             cfg_q;
    logic [CNT_W-1:0] match_q, shadow_q;
    logic             clr_req_q, match_seen_q, pub_seen_q, irq_q;
    logic [BUS_W-1:0] rdata_q, rd_mux;
    logic             clr_pend;

    assign clr_pend = (clr_req_q != clr_ack_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            match_q   <= '0;
            clr_req_q <= 1'b0;
        end else if (bus_en && bus_we) begin
            case (sel)
                SEL_MATCH: match_q <= bus_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    cfg_q.run      <= bus_wdata[0];
                    cfg_q.periodic <= bus_wdata[1];
                end
                SEL_DIV:   cfg_q.div <= bus_wdata[DIV_W-1:0];
                SEL_CLEAR: clr_req_q <= ~clr_req_q;
                default: ;
            endcase
        end
    end

    // match events: one pulse per toggle seen from the count domain
    always_ff @(posedge clk) begin
        if (rst) begin
            match_seen_q <= 1'b0;
            irq_q        <= 1'b0;
        end else begin
            match_seen_q <= match_tgl_s;
            irq_q        <= (match_tgl_s != match_seen_q);
        end
    end

    // count snapshot capture
    always_ff @(posedge clk) begin
        if (rst) begin
            pub_seen_q <= 1'b0;
            shadow_q   <= '0;
        end else if (pub_tgl_s != pub_seen_q) begin
            pub_seen_q <= pub_tgl_s;
            shadow_q   <= pub_data_i;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_MATCH: rd_mux[CNT_W-1:0] = match_q;
            SEL_COUNT: rd_mux[CNT_W-1:0] = shadow_q;
            SEL_CTRL:  rd_mux[1:0]       = {cfg_q.periodic, cfg_q.run};
            SEL_DIV:   rd_mux[DIV_W-1:0] = cfg_q.div;
            SEL_STAT:  rd_mux[PEND_BIT]  = clr_pend;
            default:   rd_mux            = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_en && !bus_we)
            rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign cfg_o      = cfg_q;
    assign match_o    = match_q;
    assign clr_req_o  = clr_req_q;
    assign pub_ack_o  = pub_seen_q;
    assign irq_o      = irq_q;
    assign clr_pend_o = clr_pend;
endmodule

// File: rtl/match_timer.sv
module match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clk,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic             rst_cnt;
    cfg_t             cfg;
    logic [CNT_W-1:0] match_val, cnt_q, cnt_match, pub_data;
    logic             clr_req, clr_ack, match_tgl, pub_tgl, pub_ack;
    logic             cnt_tick, clr_hit, cnt_run, cnt_periodic, clr_pend;

    tmr_sync #(.WIDTH(1)) u_rst_sync (
        .clk(cnt_clk), .rst(1'b0), .d(rst), .q(rst_cnt)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_o(cfg), .match_o(match_val), .clr_req_o(clr_req),
        .clr_ack_i(clr_ack), .match_tgl_i(match_tgl),
        .pub_tgl_i(pub_tgl), .pub_data_i(pub_data), .pub_ack_o(pub_ack),
        .irq_o(irq), .clr_pend_o(clr_pend)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(cnt_clk), .rst(rst_cnt),
        .cfg_i(cfg), .match_i(match_val),
        .clr_req_i(clr_req), .pub_ack_i(pub_ack),
        .count_o(cnt_q), .tick_o(cnt_tick), .clr_hit_o(clr_hit),
        .run_o(cnt_run), .periodic_o(cnt_periodic), .match_o(cnt_match),
        .match_tgl_o(match_tgl), .clr_ack_o(clr_ack),
        .pub_tgl_o(pub_tgl), .pub_data_o(pub_data)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_clk,
    input logic              rst_cnt,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic              clr_pend,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cnt_tick,
    input logic              cnt_run,
    input logic              cnt_periodic,
    input logic [CNT_W-1:0]  cnt_match,
    input logic              clr_hit,
    input logic              match_tgl
);
    p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_clear_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && decode_addr(bus_addr) == SEL_CLEAR) |=> clr_pend);

    p_clear_zero_r8: assert property (@(posedge cnt_clk) disable iff (rst || rst_cnt)
        clr_hit |=> (cnt_q == '0));

    p_frozen_r7: assert property (@(posedge cnt_clk) disable iff (rst || rst_cnt)
        (!cnt_run && !clr_hit) |=> $stable(cnt_q));

    p_quiet_r7: assert property (@(posedge cnt_clk) disable iff (rst || rst_cnt)
        !cnt_run |=> $stable(match_tgl));

    p_wrap_r5: assert property (@(posedge cnt_clk) disable iff (rst || rst_cnt)
        (cnt_tick && !cnt_periodic && (&cnt_q)) |=> (cnt_q == '0));

    p_reload_r6: assert property (@(posedge cnt_clk) disable iff (rst || rst_cnt)
        (cnt_tick && cnt_periodic && cnt_q == cnt_match) |=> (cnt_q == '0));
endmodule

bind match_timer tmr_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .rst_cnt(rst_cnt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .irq(irq), .clr_pend(clr_pend), .cnt_q(cnt_q), .cnt_tick(cnt_tick),
    .cnt_run(cnt_run), .cnt_periodic(cnt_periodic), .cnt_match(cnt_match),
    .clr_hit(clr_hit), .match_tgl(match_tgl)
);

// File: tb/test_match_timer.sv
module test_match_timer;
    localparam int CLK_PERIOD = 10;
    localparam int RATIO      = 3;
    localparam int TW         = 8;

    logic        clk = 1'b0, cnt_clk = 1'b0, rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0, bad = 0;
    int cyc = 0, irq_cnt = 0, last_irq = 0, prev_irq = 0, dbl = 0;
    logic irq_prev = 1'b0;
    bit   done = 0;

    match_timer #(.CNT_W(TW)) i_match_timer (
        .clk(clk), .rst(rst), .cnt_clk(cnt_clk),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #2;
        forever #(CLK_PERIOD*RATIO/2) cnt_clk = ~cnt_clk;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (irq) begin
            irq_cnt  <= irq_cnt + 1;
            prev_irq <= last_irq;
            last_irq <= cyc;
            if (irq_prev) dbl <= dbl + 1;
        end
        irq_prev <= irq;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_clear_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            rd(5'h14, s);
            if (!s[10]) begin ok = 1; break; end
        end
    endtask

    task automatic wait_irqs(input int n, output bit ok);
        int target;
        target = irq_cnt + n;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq_cnt >= target) begin ok = 1; break; end
        end
    endtask

    task automatic setup(input int div, input int m, input bit per);
        bit ok;
        wr(5'h08, 32'd0);
        wr(5'h10, div);
        wr(5'h00, m);
        wr(5'h0C, 32'd0);
        wait_clear_done(ok);
        wr(5'h08, {30'd0, per, 1'b1});
    endtask

    initial begin
        logic [31:0] v, c0, c1;
        bit ok;
        int ival, snap;
        repeat (20) @(negedge clk);
        rst = 1'b0;
        idle(20);

        // R1: reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        for (int k = 0; k < 6; k++) begin
            rd(5'(k*4), v);
            check(v == 0, "R1 register", v, 0);
        end

        // R2: readback of writable registers
        wr(5'h00, 32'h0000_00A5); rd(5'h00, v); check(v == 32'hA5, "R2 match", v, 32'hA5);
        wr(5'h08, 32'h0000_0002); rd(5'h08, v); check(v == 32'h2, "R2 ctrl", v, 2);
        wr(5'h10, 32'h0000_0003); rd(5'h10, v); check(v == 32'h3, "R2 div", v, 3);
        rd(5'h0C, v); check(v == 0, "R2 clear reads zero", v, 0);

        // R6 with R3: periodic interval sweep over divider and compare value
        for (int d = 0; d < 4; d++) begin
            for (int mi = 0; mi < 4; mi++) begin
                int m;
                m = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 4 : 9;
                setup(d, m, 1'b1);
                wait_irqs(3, ok);
                ival = last_irq - prev_irq;
                check(ok && ival == (m + 1) * (d + 1) * RATIO, "R6 periodic interval",
                      ival, (m + 1) * (d + 1) * RATIO);
            end
        end

        // R3: free-running interval with divide-by-4
        setup(3, 7, 1'b0);
        wait_irqs(2, ok);
        ival = last_irq - prev_irq;
        check(ok && ival == 256 * 4 * RATIO, "R3 divide-by-4 wrap interval", ival, 256 * 4 * RATIO);

        // R5: free-running wraps every 2^TW steps, count passes the compare value
        setup(0, 5, 1'b0);
        wait_irqs(2, ok);
        ival = last_irq - prev_irq;
        check(ok && ival == 256 * RATIO, "R5 wrap interval", ival, 256 * RATIO);
        idle(60);
        wr(5'h08, 32'd0);
        idle(60);
        rd(5'h04, c0);
        check(c0 > 5 && c0 < 256, "R5 counts past match", c0, 6);

        // R7: frozen count and no events while stopped
        snap = irq_cnt;
        idle(400);
        rd(5'h04, c1);
        check(c1 == c0, "R7 frozen count", c1, c0);
        check(irq_cnt == snap, "R7 no irq while stopped", irq_cnt, snap);

        // R2: count register ignores writes
        wr(5'h04, 32'h0000_0003);
        idle(60);
        rd(5'h04, v);
        check(v == c0, "R2 count write ignored", v, c0);

        // R9 and R8: clear with arbitrary data
        wr(5'h0C, 32'h1234_5678);
        rd(5'h14, v);
        check(v[10] == 1'b1, "R9 pending right after clear", v[10], 1);
        wait_clear_done(ok);
        check(ok, "R9 pending drops", ok, 1);
        idle(60);
        rd(5'h04, v);
        check(v == 0, "R8 count cleared", v, 0);

        // R4: all pulses were one bus cycle wide
        check(dbl == 0, "R4 single-cycle irq", dbl, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule